// File: doc/BRIEF.md
# Clustered Core-to-Monitor Interconnect

This block links a small cluster of processor cores to a larger pool of control-flow monitors. Each core emits a stream of instruction hashes with a valid strobe. A per-core select field decides which monitor receives that stream, so a core is always checked by the monitor that holds the graph for its current workload. A violation raised by a monitor is steered back as a reset to the core that currently owns that monitor, and to no other core.

Software stages a new mapping with a configuration write. The write is screened before it is stored, and the mapping goes live only on a separate commit strobe. On commit, every monitor whose owner changes receives a one-cycle restart pulse so that it begins again from its start state. Graph images enter the monitor memories only through a dedicated load port, never from the cores. A monitor that is being loaded is busy and cannot be mapped.

The monitors are stored in pairs. Each pair shares one dual-ported memory that is split into two halves. Port A serves the even monitor and port B serves the odd monitor, so the two can walk different graphs in the same cycle. A load beat for a monitor uses that monitor's own port.

Top module: `cfm_cluster_xbar`

## Requirements
- R1: After reset, every core is unmapped. The active map reads all ones, with each 3-bit field equal to 7. No monitor sees a valid strobe, no core reset is raised, and no monitor is busy. The error flag is 0 and no restart pulse is active.
- R2: A configuration write changes only the staged map. The active map (`cfg_map_o`, core c in bits [3c+2:3c]) takes the staged value in the cycle after an accepted commit, and it holds at every other time.
- R3: A select value of 6 or 7 leaves a core unmapped. Its hash and valid strobe reach no monitor, and no violation reaches it.
- R4: A write in which two cores name the same monitor (select below 6) is rejected. The staged map is kept and the error flag is set. An accepted write clears the flag.
- R5: A monitor owned by core c outputs core c's hash and valid strobe in the same cycle. A monitor with no owner outputs hash 0 and valid 0.
- R6: A core's reset output equals the violation input of the monitor it is actively mapped to.
- R7: An accepted commit raises the restart output, for exactly one cycle (the cycle after the commit), on each monitor whose owner differs between the old and the new map. Unmapped counts as an owner state.
- R8: A load beat that is accepted writes its data word at that monitor's graph address. The monitor is busy from an accepted beat with last=0 until an accepted beat with last=1. At most one monitor is busy at any time.
- R9: A write that names a busy monitor, or a monitor being claimed by a load beat in that cycle, is rejected and sets the error flag. A commit whose staged map names such a monitor is refused, leaves the active map unchanged, and sets the error flag.
- R10: A load beat is ignored and leaves memory and busy state unchanged if it names a monitor of 6 or above, a monitor in the active map, or a monitor other than the one already busy.
- R11: Each monitor reads its own graph through its own port. The read data appears one cycle after the address, and both monitors of a pair can read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_hash_i | input | 16 | Per-core instruction hash, core c in bits [4c+3:4c] |
| core_valid_i | input | 4 | Per-core hash valid |
| core_rst_o | output | 4 | Per-core reset from the owning monitor's violation |
| mon_hash_o | output | 24 | Per-monitor routed hash |
| mon_valid_o | output | 6 | Per-monitor routed valid |
| mon_restart_o | output | 6 | Restart pulse on a change of ownership |
| mon_viol_i | input | 6 | Per-monitor violation |
| mon_rd_addr_i | input | 24 | Per-monitor graph read address |
| mon_rd_data_o | output | 96 | Per-monitor graph read data |
| cfg_we_i | input | 1 | Stage a new map |
| cfg_sel_i | input | 12 | Map to be staged, 3 bits per core |
| cfg_commit_i | input | 1 | Apply the staged map |
| cfg_map_o | output | 12 | Active map |
| cfg_err_o | output | 1 | Last configuration action was refused |
| ld_valid_i | input | 1 | Load beat valid |
| ld_mon_i | input | 3 | Monitor being loaded |
| ld_addr_i | input | 4 | Graph address |
| ld_data_i | input | 16 | Graph word |
| ld_last_i | input | 1 | Final beat of the image |
| mon_busy_o | output | 6 | Monitor currently being loaded |

## Verification
The assertions assume that reset is held across the first clock edge and that the strobes change only away from the edge. The per-cycle routing checks also assume that the hash, valid and violation inputs are always driven to known values. The bench applies every input at the falling edge and drives each of them to a defined value in every cycle. The random phase still draws select fields and load monitor ids from the full 3-bit range, so the out-of-range, duplicate and busy paths are all reached.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned CFM_CORES  = 4;
  localparam int unsigned CFM_MONS   = 6;
  localparam int unsigned CFM_SEL_W  = 3;
  localparam int unsigned CFM_HASH_W = 4;
  localparam int unsigned CFM_ADDR_W = 4;
  localparam int unsigned CFM_DATA_W = 16;

  typedef enum logic [1:0] {CFG_HOLD, CFG_TAKE, CFG_DENY} cfg_evt_e;
endpackage

// File: rtl/cfm_graph_mem.sv
module cfm_graph_mem #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_waddr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [ADDR_W-1:0] a_raddr_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_waddr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic [ADDR_W-1:0] b_raddr_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned DEPTH = 2 ** (ADDR_W + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];

  // lower half belongs to port A, upper half to port B
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[{1'b0, a_waddr_i}] <= a_wdata_i;
    else        a_rdata_o <= mem_q[{1'b0, a_raddr_i}];
    if (b_we_i) mem_q[{1'b1, b_waddr_i}] <= b_wdata_i;
    else        b_rdata_o <= mem_q[{1'b1, b_raddr_i}];
  end
endmodule

// File: rtl/cfm_cfg_ctrl.sv
module cfm_cfg_ctrl
  import cfm_pkg::*;
#(
  parameter int unsigned N_CORES = CFM_CORES,
  parameter int unsigned N_MONS  = CFM_MONS,
  parameter int unsigned SEL_W   = CFM_SEL_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [N_CORES*SEL_W-1:0] sel_i,
  input  logic                     commit_i,
  input  logic [N_MONS-1:0]        blocked_i,
  output logic [N_CORES*SEL_W-1:0] act_sel_o,
  output logic                     err_o,
  output logic [N_MONS-1:0]        restart_o,
  output logic [N_MONS-1:0]        act_mapped_o
);
  localparam int unsigned CIDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int unsigned MAP_W  = N_CORES * SEL_W;

  logic [MAP_W-1:0]  stg_q, act_q;
  logic              err_q;
  logic [N_MONS-1:0] restart_q, chg;
  logic [N_MONS-1:0] act_own_v, stg_own_v;
  logic [CIDX_W-1:0] act_own_i [N_MONS];
  logic [CIDX_W-1:0] stg_own_i [N_MONS];
  logic              wr_dup, wr_blk, stg_blk;
  cfg_evt_e          wr_evt, cm_evt;

  always_comb begin
    act_own_v = '0;
    stg_own_v = '0;
    stg_blk   = 1'b0;
    for (int m = 0; m < N_MONS; m++) begin
      act_own_i[m] = '0;
      stg_own_i[m] = '0;
      for (int c = 0; c < N_CORES; c++) begin
        if (act_q[c*SEL_W +: SEL_W] == SEL_W'(m)) begin
          act_own_v[m] = 1'b1;
          act_own_i[m] = CIDX_W'(c);
        end
        if (stg_q[c*SEL_W +: SEL_W] == SEL_W'(m)) begin
          stg_own_v[m] = 1'b1;
          stg_own_i[m] = CIDX_W'(c);
          stg_blk      = stg_blk | blocked_i[m];
        end
      end
      chg[m] = (act_own_v[m] != stg_own_v[m]) || (act_own_i[m] != stg_own_i[m]);
    end
  end

  always_comb begin
    wr_dup = 1'b0;
    wr_blk = 1'b0;
    for (int c = 0; c < N_CORES; c++) begin
      for (int m = 0; m < N_MONS; m++)
        if (sel_i[c*SEL_W +: SEL_W] == SEL_W'(m)) wr_blk = wr_blk | blocked_i[m];
      for (int d = c + 1; d < N_CORES; d++)
        if (sel_i[c*SEL_W +: SEL_W] == sel_i[d*SEL_W +: SEL_W] &&
            sel_i[c*SEL_W +: SEL_W] < SEL_W'(N_MONS)) wr_dup = 1'b1;
    end
    wr_evt = !we_i ? CFG_HOLD : (wr_dup || wr_blk) ? CFG_DENY : CFG_TAKE;
    cm_evt = !commit_i ? CFG_HOLD : stg_blk ? CFG_DENY : CFG_TAKE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q     <= '1;
      act_q     <= '1;
      err_q     <= 1'b0;
      restart_q <= '0;
    end else begin
      restart_q <= (cm_evt == CFG_TAKE) ? chg : '0;
      if (cm_evt == CFG_TAKE) act_q <= stg_q;
      if (wr_evt == CFG_TAKE) stg_q <= sel_i;
      if (wr_evt != CFG_HOLD)      err_q <= (wr_evt == CFG_DENY);
      else if (cm_evt == CFG_DENY) err_q <= 1'b1;
    end
  end

  assign act_sel_o    = act_q;
  assign err_o        = err_q;
  assign restart_o    = restart_q;
  assign act_mapped_o = act_own_v;

  AST_MAP_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q)); // R2
  AST_RESTART_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |restart_q |-> $past(commit_i)); // R7
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(we_i || commit_i)); // R4
endmodule

// File: rtl/cfm_route.sv
module cfm_route
  import cfm_pkg::*;
#(
  parameter int unsigned N_CORES = CFM_CORES,
  parameter int unsigned N_MONS  = CFM_MONS,
  parameter int unsigned SEL_W   = CFM_SEL_W,
  parameter int unsigned HASH_W  = CFM_HASH_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES*SEL_W-1:0]  act_sel_i,
  input  logic [N_CORES*HASH_W-1:0] core_hash_i,
  input  logic [N_CORES-1:0]        core_valid_i,
  input  logic [N_MONS-1:0]         mon_viol_i,
  output logic [N_MONS*HASH_W-1:0]  mon_hash_o,
  output logic [N_MONS-1:0]         mon_valid_o,
  output logic [N_CORES-1:0]        core_rst_o
);
  // per-core demux forward, per-core mux back; ownership is unique by config
  always_comb begin
    mon_hash_o  = '0;
    mon_valid_o = '0;
    core_rst_o  = '0;
    for (int c = 0; c < N_CORES; c++) begin
      for (int m = 0; m < N_MONS; m++) begin
        if (act_sel_i[c*SEL_W +: SEL_W] == SEL_W'(m)) begin
          mon_hash_o[m*HASH_W +: HASH_W] = core_hash_i[c*HASH_W +: HASH_W];
          mon_valid_o[m]                 = core_valid_i[c];
          core_rst_o[c]                  = mon_viol_i[m];
        end
      end
    end
  end

  AST_RST_NEEDS_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |core_rst_o |-> |mon_viol_i); // R6
  AST_VALID_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |mon_valid_o |-> |core_valid_i); // R5
  AST_VALID_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mon_valid_o) <= $countones(core_valid_i)); // R3
endmodule

// File: rtl/cfm_load_ctrl.sv
module cfm_load_ctrl
  import cfm_pkg::*;
#(
  parameter int unsigned N_MONS = CFM_MONS,
  parameter int unsigned SEL_W  = CFM_SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [SEL_W-1:0]  ld_mon_i,
  input  logic              ld_last_i,
  input  logic [N_MONS-1:0] act_mapped_i,
  output logic [N_MONS-1:0] claim_o,
  output logic [N_MONS-1:0] busy_o
);
  logic [N_MONS-1:0] busy_q, hit;
  logic              accept;

  always_comb begin
    for (int m = 0; m < N_MONS; m++) hit[m] = (ld_mon_i == SEL_W'(m));
    accept  = ld_valid_i && |hit && !(|(hit & act_mapped_i)) &&
              (busy_q == '0 || |(hit & busy_q));
    claim_o = accept ? hit : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= '0;
    else if (accept) busy_q <= ld_last_i ? '0 : hit;
  end

  assign busy_o = busy_q;

  AST_BUSY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_q)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> $stable(busy_q)); // R8
  AST_BUSY_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q & act_mapped_i) == '0); // R9
endmodule

// File: rtl/cfm_cluster_xbar.sv
module cfm_cluster_xbar
  import cfm_pkg::*;
#(
  parameter int unsigned N_CORES = CFM_CORES,
  parameter int unsigned N_MONS  = CFM_MONS,
  parameter int unsigned SEL_W   = CFM_SEL_W,
  parameter int unsigned HASH_W  = CFM_HASH_W,
  parameter int unsigned ADDR_W  = CFM_ADDR_W,
  parameter int unsigned DATA_W  = CFM_DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES*HASH_W-1:0] core_hash_i,
  input  logic [N_CORES-1:0]        core_valid_i,
  output logic [N_CORES-1:0]        core_rst_o,
  output logic [N_MONS*HASH_W-1:0]  mon_hash_o,
  output logic [N_MONS-1:0]         mon_valid_o,
  output logic [N_MONS-1:0]         mon_restart_o,
  input  logic [N_MONS-1:0]         mon_viol_i,
  input  logic [N_MONS*ADDR_W-1:0]  mon_rd_addr_i,
  output logic [N_MONS*DATA_W-1:0]  mon_rd_data_o,
  input  logic                      cfg_we_i,
  input  logic [N_CORES*SEL_W-1:0]  cfg_sel_i,
  input  logic                      cfg_commit_i,
  output logic [N_CORES*SEL_W-1:0]  cfg_map_o,
  output logic                      cfg_err_o,
  input  logic                      ld_valid_i,
  input  logic [SEL_W-1:0]          ld_mon_i,
  input  logic [ADDR_W-1:0]         ld_addr_i,
  input  logic [DATA_W-1:0]         ld_data_i,
  input  logic                      ld_last_i,
  output logic [N_MONS-1:0]         mon_busy_o
);
  localparam int unsigned N_PAIRS = N_MONS / 2;
  localparam int unsigned MAP_W   = N_CORES * SEL_W;

  logic [MAP_W-1:0]  act_sel;
  logic [N_MONS-1:0] act_mapped, claim, busy;

  cfm_cfg_ctrl #(.N_CORES(N_CORES), .N_MONS(N_MONS), .SEL_W(SEL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .commit_i(cfg_commit_i),
    .blocked_i(busy | claim),
    .act_sel_o(act_sel), .err_o(cfg_err_o), .restart_o(mon_restart_o),
    .act_mapped_o(act_mapped)
  );

  cfm_route #(.N_CORES(N_CORES), .N_MONS(N_MONS), .SEL_W(SEL_W), .HASH_W(HASH_W)) u_route (
    .clk_i, .rst_ni,
    .act_sel_i(act_sel), .core_hash_i, .core_valid_i, .mon_viol_i,
    .mon_hash_o, .mon_valid_o, .core_rst_o
  );

  cfm_load_ctrl #(.N_MONS(N_MONS), .SEL_W(SEL_W)) u_load (
    .clk_i, .rst_ni,
    .ld_valid_i, .ld_mon_i, .ld_last_i,
    .act_mapped_i(act_mapped), .claim_o(claim), .busy_o(busy)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    cfm_graph_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk_i,
      .a_we_i   (claim[2*p]),
      .a_waddr_i(ld_addr_i),
      .a_wdata_i(ld_data_i),
      .a_raddr_i(mon_rd_addr_i[(2*p)*ADDR_W +: ADDR_W]),
      .a_rdata_o(mon_rd_data_o[(2*p)*DATA_W +: DATA_W]),
      .b_we_i   (claim[2*p+1]),
      .b_waddr_i(ld_addr_i),
      .b_wdata_i(ld_data_i),
      .b_raddr_i(mon_rd_addr_i[(2*p+1)*ADDR_W +: ADDR_W]),
      .b_rdata_o(mon_rd_data_o[(2*p+1)*DATA_W +: DATA_W])
    );
  end

  assign cfg_map_o  = act_sel;
  assign mon_busy_o = busy;

  AST_LOAD_NOT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim & act_mapped) == '0); // R10
endmodule

// File: tb/cfm_cluster_xbar_tb_top.sv
module cfm_cluster_xbar_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 4, NM = 6, SW = 3, HW = 4, AW = 4, DW = 16;
  localparam int GD = 2 ** AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC*HW-1:0] core_hash;
  logic [NC-1:0]    core_valid, core_rst;
  logic [NM*HW-1:0] mon_hash;
  logic [NM-1:0]    mon_valid, mon_restart, mon_viol, mon_busy;
  logic [NM*AW-1:0] rd_addr;
  logic [NM*DW-1:0] rd_data;
  logic             cfg_we, cfg_commit, cfg_err;
  logic [NC*SW-1:0] cfg_sel, cfg_map;
  logic             ld_valid, ld_last;
  logic [SW-1:0]    ld_mon;
  logic [AW-1:0]    ld_addr;
  logic [DW-1:0]    ld_data;

  always #2 clk = ~clk;

  cfm_cluster_xbar dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .core_hash_i(core_hash), .core_valid_i(core_valid), .core_rst_o(core_rst),
    .mon_hash_o(mon_hash), .mon_valid_o(mon_valid), .mon_restart_o(mon_restart),
    .mon_viol_i(mon_viol), .mon_rd_addr_i(rd_addr), .mon_rd_data_o(rd_data),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_commit_i(cfg_commit),
    .cfg_map_o(cfg_map), .cfg_err_o(cfg_err),
    .ld_valid_i(ld_valid), .ld_mon_i(ld_mon), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .ld_last_i(ld_last), .mon_busy_o(mon_busy)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int          act[NC], stg[NC];
  bit          m_err;
  bit [NM-1:0] m_busy, m_rst;
  logic [DW-1:0] gmem[NM][GD];
  bit            gwr[NM][GD];
  logic [DW-1:0] exp_rd[NM];
  bit            exp_rd_v[NM];

  task automatic chk(bit ok, string req, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, a, e);
    end
  endtask

  function automatic int own(input int mp[NC], input int m);
    for (int c = 0; c < NC; c++) if (mp[c] == m) return c;
    return -1;
  endfunction

  function automatic int fld(input logic [NC*SW-1:0] v, input int c);
    return int'(v[c*SW +: SW]);
  endfunction

  task automatic check_comb();
    for (int m = 0; m < NM; m++) begin
      int o = own(act, m);
      logic         ev = (o >= 0) ? core_valid[o] : 1'b0;
      logic [HW-1:0] eh = (o >= 0) ? core_hash[o*HW +: HW] : '0;
      chk(mon_valid[m] == ev, o < 0 ? "R3 mon_valid" : "R5 mon_valid", mon_valid[m], ev);
      chk(mon_hash[m*HW +: HW] == eh, "R5 mon_hash", mon_hash[m*HW +: HW], eh);
    end
    for (int c = 0; c < NC; c++) begin
      logic er = (act[c] < NM) ? mon_viol[act[c]] : 1'b0;
      chk(core_rst[c] == er, act[c] < NM ? "R6 core_rst" : "R3 core_rst", core_rst[c], er);
    end
  endtask

  task automatic check_regs();
    logic [NC*SW-1:0] em;
    for (int c = 0; c < NC; c++) em[c*SW +: SW] = SW'(act[c]);
    chk(cfg_map == em, "R2 cfg_map", cfg_map, em);
    chk(cfg_err == m_err, "R4 R9 cfg_err", cfg_err, m_err);
    chk(mon_busy == m_busy, "R8 busy", mon_busy, m_busy);
    chk(mon_restart == m_rst, "R7 restart", mon_restart, m_rst);
    for (int m = 0; m < NM; m++)
      if (exp_rd_v[m]) chk(rd_data[m*DW +: DW] == exp_rd[m], "R11 rd_data",
                           rd_data[m*DW +: DW], exp_rd[m]);
  endtask

  task automatic model_step();
    int lm = int'(ld_mon);
    bit acc;
    bit [NM-1:0] claim, blk, nrst;
    bit dup, wblk, sblk;
    int nsel[NC];
    acc   = ld_valid && lm < NM && own(act, lm) < 0 && (m_busy == 0 || m_busy[lm]);
    claim = acc ? NM'(1 << lm) : '0;
    blk   = m_busy | claim;
    for (int m = 0; m < NM; m++) begin
      int a = int'(rd_addr[m*AW +: AW]);
      exp_rd_v[m] = !claim[m] && gwr[m][a];
      exp_rd[m]   = gmem[m][a];
    end
    dup = 0; wblk = 0; sblk = 0;
    for (int c = 0; c < NC; c++) begin
      nsel[c] = fld(cfg_sel, c);
      if (nsel[c] < NM && blk[nsel[c]]) wblk = 1;
      if (stg[c] < NM && blk[stg[c]]) sblk = 1;
      for (int d = 0; d < c; d++) if (nsel[d] == nsel[c] && nsel[c] < NM) dup = 1;
    end
    nrst = '0;
    if (cfg_commit && !sblk) begin
      for (int m = 0; m < NM; m++) nrst[m] = own(act, m) != own(stg, m);
      act = stg;
    end
    if (cfg_we) m_err = dup || wblk;
    else if (cfg_commit && sblk) m_err = 1;
    if (cfg_we && !dup && !wblk) stg = nsel;
    if (acc) begin
      gmem[lm][ld_addr] = ld_data;
      gwr[lm][ld_addr]  = 1;
      m_busy = ld_last ? '0 : claim;
    end
    m_rst = nrst;
  endtask

  task automatic tick();
    #1;
    check_comb();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_regs();
    cfg_we = 0; cfg_commit = 0; ld_valid = 0;
  endtask

  task automatic set_map(int a, int b, int c, int d);
    cfg_sel = {SW'(d), SW'(c), SW'(b), SW'(a)};
    cfg_we  = 1;
    tick();
  endtask

  task automatic do_commit();
    cfg_commit = 1;
    tick();
  endtask

  task automatic ld(int m, int a, int dat, bit last);
    ld_valid = 1; ld_mon = SW'(m); ld_addr = AW'(a); ld_data = DW'(dat); ld_last = last;
    tick();
  endtask

  task automatic rand_data();
    core_hash  = NC*HW'($urandom);
    core_valid = NC'($urandom);
    mon_viol   = NM'($urandom);
    rd_addr    = NM*AW'($urandom);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3a));
    core_hash = '0; core_valid = '0; mon_viol = '0; rd_addr = '0;
    cfg_we = 0; cfg_commit = 0; cfg_sel = '1;
    ld_valid = 0; ld_mon = '0; ld_addr = '0; ld_data = '0; ld_last = 0;
    for (int c = 0; c < NC; c++) begin act[c] = 7; stg[c] = 7; end
    m_err = 0; m_busy = '0; m_rst = '0;
    for (int m = 0; m < NM; m++) begin
      exp_rd_v[m] = 0;
      for (int a = 0; a < GD; a++) begin gwr[m][a] = 0; gmem[m][a] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    core_valid = '1; mon_viol = '1; core_hash = '1;
    #1;
    // R1 reset state
    chk(cfg_map == '1, "R1 map", cfg_map, '1);
    chk(cfg_err == 0, "R1 err", cfg_err, 0);
    chk(mon_busy == 0, "R1 busy", mon_busy, 0);
    chk(mon_restart == 0, "R1 restart", mon_restart, 0);
    chk(mon_valid == 0, "R1 mon_valid", mon_valid, 0);
    chk(core_rst == 0, "R1 core_rst", core_rst, 0);

    // R8: load every graph in multi-beat images
    for (int m = 0; m < NM; m++)
      for (int a = 0; a < GD; a++) begin
        ld(m, a, $urandom, a == GD - 1);
        if (a == 2) chk(mon_busy == NM'(1 << m), "R8 busy mid-load", mon_busy, 1 << m);
        if (a == 3) begin
          ld((m + 1) % NM, 0, 16'hbad0, 1); // R10 other monitor while busy
          chk(mon_busy == NM'(1 << m), "R10 busy kept", mon_busy, 1 << m);
        end
      end
    ld(7, 0, 0, 0); // R10 out-of-range id
    chk(mon_busy == 0, "R10 id 7", mon_busy, 0);

    // R11: concurrent reads on both ports of each pair
    for (int a = 0; a < GD; a++) begin
      for (int m = 0; m < NM; m++) rd_addr[m*AW +: AW] = AW'((a + m) % GD);
      tick();
    end
    tick();

    // R2 R7: staged only until commit
    rand_data();
    set_map(0, 1, 2, 3);
    chk(cfg_map == '1, "R2 staged not live", cfg_map, '1);
    do_commit();
    chk(mon_restart == 6'b001111, "R7 restart 0-3", mon_restart, 6'b001111);
    tick();
    chk(mon_restart == 0, "R7 pulse one cycle", mon_restart, 0);

    // R4 duplicate rejected, staged kept
    set_map(4, 4, 6, 7);
    chk(cfg_err == 1, "R4 dup err", cfg_err, 1);
    do_commit();
    chk(mon_restart == 0, "R4 staged kept", mon_restart, 0);

    // R3 unmapped cores, R10 load to live monitor
    set_map(5, 6, 7, 0);
    chk(cfg_err == 0, "R4 err cleared", cfg_err, 0);
    do_commit();
    chk(mon_restart == 6'b101111, "R7 owner change", mon_restart, 6'b101111);
    ld(0, 5, 16'hdead, 1);
    chk(mon_busy == 0, "R10 mapped load", mon_busy, 0);
    rd_addr = '0; rd_addr[0 +: AW] = 4'd5;
    tick();
    tick();
    for (int k = 0; k < 6; k++) begin rand_data(); tick(); end

    // R9 busy monitor blocks write and commit
    ld(4, 0, 16'h1111, 0);
    set_map(4, 1, 6, 6);
    chk(cfg_err == 1, "R9 write to busy", cfg_err, 1);
    set_map(1, 2, 3, 6);
    ld(4, 1, 16'h2222, 1);
    ld(1, 0, 16'h3333, 0);
    do_commit();
    chk(cfg_err == 1, "R9 commit refused", cfg_err, 1);
    ld(1, 1, 16'h4444, 1);
    do_commit();
    chk(cfg_err == 1, "R9 err held", cfg_err, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      rand_data();
      if ($urandom_range(7, 0) == 0) begin
        int pool[8];
        for (int k = 0; k < 8; k++) pool[k] = k;
        for (int k = 7; k > 0; k--) begin
          int j = $urandom_range(k, 0);
          int t = pool[k]; pool[k] = pool[j]; pool[j] = t;
        end
        if ($urandom_range(1, 0) == 1) cfg_sel = {SW'(pool[3]), SW'(pool[2]), SW'(pool[1]), SW'(pool[0])};
        else cfg_sel = NC*SW'($urandom);
        cfg_we = 1;
      end
      if ($urandom_range(9, 0) == 0) cfg_commit = 1;
      if ($urandom_range(3, 0) == 0) begin
        ld_valid = 1; ld_mon = SW'($urandom); ld_addr = AW'($urandom);
        ld_data = DW'($urandom); ld_last = ($urandom_range(3, 0) == 0);
      end
      tick();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule